// File: doc/BRIEF.md
# Nibble ALU with 4x4 Multiply

This block is a purely combinational arithmetic-logic unit. It takes two 4-bit unsigned operands, a 3-bit operation code and one auxiliary carry/borrow bit. It returns an 8-bit result, a carry/borrow flag and an overflow flag.

The operation code first passes through a decoder that raises at most one select line. That line picks the output of one unit: the adder/subtractor, the shift-and-add multiplier or the bitwise unit. The auxiliary bit is the carry into an addition and the borrow into a subtraction. Every other operation ignores it.

Only multiplication drives the upper result nibble. Codes that have no operation give an all-zero result with both flags low. The block holds no state, so the outputs follow the inputs directly.

Top module: `nib_alu`

## Requirements
- R1: With code 3'b000 (add), result[3:0] equals (A + B + aux) mod 16 and cb_out equals bit 4 of that 5-bit sum.
- R2: With code 3'b001 (subtract), result[3:0] equals (A - B - aux) mod 16, and cb_out is 1 exactly when A < B + aux.
- R3: ovf is 1 only under code 3'b000, and there exactly when A[3] equals B[3] and result[3] differs from A[3]. It is 0 for every other code.
- R4: With code 3'b010 (multiply), result[7:0] equals A * B as an 8-bit unsigned product.
- R5: Codes 3'b100, 3'b101 and 3'b110 give A AND B, A OR B and A XOR B on result[3:0].
- R6: Codes 3'b011 and 3'b111 give result 0, cb_out 0 and ovf 0 whatever the operands and aux.
- R7: result[7:4] is 0 under every code except 3'b010.
- R8: Under multiply and the three bitwise codes, cb_out and ovf are 0, and aux does not change result.
- R9: The outputs depend on the present inputs only. No clock edge is needed between a change of input and the matching output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 4 | First unsigned operand |
| opnd_b | input | 4 | Second unsigned operand |
| op_code | input | 3 | Operation select |
| aux_cb | input | 1 | Carry-in for add, borrow-in for subtract |
| result | output | 8 | Operation result, upper nibble used by multiply only |
| cb_out | output | 1 | Carry out of add or borrow out of subtract |
| ovf | output | 1 | Two's-complement overflow of the add |

## Verification
Every result and flag is due zero cycles after its inputs change, because no register lies between any input and any output. The bench drives a new operand/code/aux combination on the falling clock edge and samples 1 ns later, well before the next rising edge. Each sample therefore reflects only that combination.

The sweep covers all 4096 combinations. For each one the bench computes the expected result and flags with integer arithmetic. A repeat of the multiply and bitwise codes with aux inverted shows that aux has no effect there.

// File: rtl/nib_alu_pkg.sv
package nib_alu_pkg;

    localparam int OPND_W = 4;
    localparam int RES_W  = 2 * OPND_W;
    localparam int CODE_W = 3;

    typedef enum logic [CODE_W-1:0] {
        OP_ADD  = 3'b000,
        OP_SUB  = 3'b001,
        OP_MUL  = 3'b010,
        OP_NA3  = 3'b011,
        OP_AND  = 3'b100,
        OP_OR   = 3'b101,
        OP_XOR  = 3'b110,
        OP_NA7  = 3'b111
    } op_e;

    typedef struct packed {
        logic add;
        logic sub;
        logic mul;
        logic band;
        logic bor;
        logic bxor;
    } sel_t;

    function automatic sel_t decode_op(logic [CODE_W-1:0] code);
        sel_t s;
        s = '0;
        case (code)
            OP_ADD:  s.add  = 1'b1;
            OP_SUB:  s.sub  = 1'b1;
            OP_MUL:  s.mul  = 1'b1;
            OP_AND:  s.band = 1'b1;
            OP_OR:   s.bor  = 1'b1;
            OP_XOR:  s.bxor = 1'b1;
            default: s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/nib_op_decode.sv
module nib_op_decode
    import nib_alu_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output sel_t              sel
);
    always_comb sel = decode_op(code);
endmodule

// File: rtl/nib_addsub.sv
module nib_addsub #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         aux,
    input  logic         do_sub,
    output logic [W-1:0] sum,
    output logic         cb,
    output logic         ovf
);
    logic [W-1:0] b_eff;
    logic [W:0]   chain;

    assign b_eff    = do_sub ? ~b : b;
    assign chain[0] = do_sub ? ~aux : aux;

    for (genvar i = 0; i < W; i++) begin : g_ripple
        assign sum[i]     = a[i] ^ b_eff[i] ^ chain[i];
        assign chain[i+1] = (a[i] & b_eff[i]) | (chain[i] & (a[i] ^ b_eff[i]));
    end

    assign cb  = do_sub ? ~chain[W] : chain[W];
    assign ovf = ~do_sub & (a[W-1] == b[W-1]) & (sum[W-1] != a[W-1]);
endmodule

// File: rtl/nib_mult.sv
module nib_mult #(
    parameter int W = 4
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] prod
);
    localparam int PW = 2 * W;

    logic [PW-1:0] acc [0:W];
    logic [PW-1:0] a_ext;

    assign a_ext  = {{(PW-W){1'b0}}, a};
    assign acc[0] = '0;

    for (genvar i = 0; i < W; i++) begin : g_rows
        logic [PW-1:0] part;
        assign part     = b[i] ? (a_ext << i) : '0;
        assign acc[i+1] = acc[i] + part;
    end

    assign prod = acc[W];
endmodule

// File: rtl/nib_logic.sv
module nib_logic
    import nib_alu_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  sel_t         sel,
    output logic [W-1:0] y
);
    always_comb begin
        y = '0;
        if (sel.band) y = a & b;
        if (sel.bor)  y = a | b;
        if (sel.bxor) y = a ^ b;
    end
endmodule

// File: rtl/nib_alu.sv
module nib_alu
    import nib_alu_pkg::*;
(
    input  logic [OPND_W-1:0] opnd_a,
    input  logic [OPND_W-1:0] opnd_b,
    input  logic [CODE_W-1:0] op_code,
    input  logic              aux_cb,
    output logic [RES_W-1:0]  result,
    output logic              cb_out,
    output logic              ovf
);
    localparam int PAD = RES_W - OPND_W;

    sel_t              sel_oh;
    logic [OPND_W-1:0] as_sum;
    logic              as_cb;
    logic              as_ovf;
    logic [RES_W-1:0]  mul_prod;
    logic [OPND_W-1:0] lg_y;
    logic              arith;

    nib_op_decode u_dec (
        .code (op_code),
        .sel  (sel_oh)
    );

    nib_addsub #(.W(OPND_W)) u_as (
        .a      (opnd_a),
        .b      (opnd_b),
        .aux    (aux_cb),
        .do_sub (sel_oh.sub),
        .sum    (as_sum),
        .cb     (as_cb),
        .ovf    (as_ovf)
    );

    nib_mult #(.W(OPND_W)) u_mul (
        .a    (opnd_a),
        .b    (opnd_b),
        .prod (mul_prod)
    );

    nib_logic #(.W(OPND_W)) u_lg (
        .a   (opnd_a),
        .b   (opnd_b),
        .sel (sel_oh),
        .y   (lg_y)
    );

    assign arith = sel_oh.add | sel_oh.sub;

    always_comb begin
        result = ({RES_W{arith}}      & {{PAD{1'b0}}, as_sum})
               | ({RES_W{sel_oh.mul}} & mul_prod)
               | {{PAD{1'b0}}, lg_y};
        cb_out = arith & as_cb;
        ovf    = sel_oh.add & as_ovf;
    end
endmodule

// File: rtl/nib_alu_chk.sv
module nib_alu_chk
    import nib_alu_pkg::*;
(
    input logic [OPND_W-1:0] opnd_a,
    input logic [OPND_W-1:0] opnd_b,
    input logic [CODE_W-1:0] op_code,
    input logic              aux_cb,
    input logic [RES_W-1:0]  result,
    input logic              cb_out,
    input logic              ovf,
    input sel_t              sel
);
    logic [OPND_W:0] add_ref;
    logic [OPND_W:0] sub_ref;
    logic            known;

    always_comb begin
        add_ref = {1'b0, opnd_a} + {1'b0, opnd_b} + {{OPND_W{1'b0}}, aux_cb};
        sub_ref = {1'b0, opnd_a} - {1'b0, opnd_b} - {{OPND_W{1'b0}}, aux_cb};
        known   = !$isunknown({opnd_a, opnd_b, op_code, aux_cb});
        if (known) begin
            // R1
            p_add_sum_r1: assert (!(op_code == 3'b000) || ({cb_out, result[OPND_W-1:0]} == add_ref))
                else $error("R1 add mismatch");
            // R2
            p_sub_diff_r2: assert (!(op_code == 3'b001) || ({cb_out, result[OPND_W-1:0]} == sub_ref))
                else $error("R2 subtract mismatch");
            // R3
            p_no_overflow_r3: assert (!ovf || (op_code == 3'b000 && opnd_a[OPND_W-1] == opnd_b[OPND_W-1]))
                else $error("R3 overflow outside add");
            // R4
            p_product_r4: assert (!(op_code == 3'b010) || (result == RES_W'(opnd_a * opnd_b)))
                else $error("R4 product mismatch");
            // R6
            p_unassigned_r6: assert (!(op_code[1:0] == 2'b11) || (result == '0 && !cb_out && !ovf))
                else $error("R6 unassigned code not zero");
            // R6: decoder raises at most one line
            p_sel_onehot_r6: assert ($onehot0(sel))
                else $error("R6 decode not one-hot");
            // R7
            p_hi_zero_r7: assert ((op_code == 3'b010) || (result[RES_W-1:OPND_W] == '0))
                else $error("R7 upper nibble set");
            // R8
            p_flags_low_r8: assert (!(sel.mul || sel.band || sel.bor || sel.bxor) || (!cb_out && !ovf))
                else $error("R8 flags set");
        end
    end
endmodule

bind nib_alu nib_alu_chk u_chk (
    .opnd_a  (opnd_a),
    .opnd_b  (opnd_b),
    .op_code (op_code),
    .aux_cb  (aux_cb),
    .result  (result),
    .cb_out  (cb_out),
    .ovf     (ovf),
    .sel     (sel_oh)
);

// File: tb/nib_alu_tb.sv
`timescale 1ns/1ps
module nib_alu_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] a, b;
    logic [2:0] code;
    logic       aux;
    logic [7:0] result;
    logic       cb_out, ovf;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    nib_alu dut_i (
        .opnd_a  (a),
        .opnd_b  (b),
        .op_code (code),
        .aux_cb  (aux),
        .result  (result),
        .cb_out  (cb_out),
        .ovf     (ovf)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s code=%0d a=%0d b=%0d aux=%0d actual=%0d expected=%0d",
                     req, code, a, b, aux, act, exp);
        end
    endtask

    function automatic string req_of(input int c);
        case (c)
            0: return "R1/R3";
            1: return "R2/R3";
            2: return "R4/R8";
            4, 5, 6: return "R5/R7/R8";
            default: return "R6";
        endcase
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int er, ec, eo, s;
        logic [7:0] r_base;
        a = '0; b = '0; code = '0; aux = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // Reset state with zero inputs (R1)
        chk("R1 reset result", int'(result), 0);
        chk("R1 reset cb", int'(cb_out), 0);
        chk("R3 reset ovf", int'(ovf), 0);

        for (int c = 0; c < 8; c++) begin
            for (int x = 0; x < 16; x++) begin
                for (int y = 0; y < 16; y++) begin
                    for (int k = 0; k < 2; k++) begin
                        @(negedge clk);
                        code = 3'(c); a = 4'(x); b = 4'(y); aux = k[0];
                        er = 0; ec = 0; eo = 0;
                        case (c)
                            0: begin
                                s  = x + y + k;
                                er = s % 16;
                                ec = s / 16;
                                eo = (((x / 8) == (y / 8)) && (((s % 16) / 8) != (x / 8))) ? 1 : 0;
                            end
                            1: begin
                                s  = x - y - k;
                                er = (s + 32) % 16;
                                ec = (s < 0) ? 1 : 0;
                            end
                            2: er = x * y;
                            4: er = x & y;
                            5: er = x | y;
                            6: er = x ^ y;
                            default: er = 0;
                        endcase
                        #1; // R9: no clock edge between drive and sample
                        chk({req_of(c), " result"}, int'(result), er);
                        chk({req_of(c), " cb_out"}, int'(cb_out), ec);
                        chk({req_of(c), " ovf"}, int'(ovf), eo);
                        // R8: aux has no effect on multiply and bitwise results
                        if (c == 2 || c >= 4) begin
                            r_base = result;
                            aux = ~aux;
                            #1;
                            chk("R8 aux ignored", int'(result), int'(r_base));
                        end
                    end
                end
            end
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule